// File: doc/BRIEF.md
# Output Idle-Level Controller with Configuration Lock

This block sits at the pin end of a timer's output stage. While the main output enable is high it passes three active waveform bits (a true/complementary pair for channel 1 and a single output for channel 2) to its registered pins. When the enable drops, each pin is parked at a programmed idle level. The channel-2 output parks at once. The channel-1 pair first holds both lines off (low) for a programmable dead-time, so the two switches it drives are never on together, and then takes its idle levels.

The three idle-level bits are loaded through a small write port. A lock level input arms write protection. Once a non-zero level has been captured, the idle bits can no longer be changed and the lock cannot be cleared by anything except reset.

Top module: `oidle_ctrl`

## Requirements
- R1: With the enable low and the pair in its dead-time, once `dt_len` cycles of dead-time have passed `pin_a` equals idle bit 0 (write-data bit 0). The dead-time counts cycles after the first edge that sees the enable low. The length is sampled on that edge.
- R2: Under the same conditions `pin_an` equals idle bit 1 (write-data bit 1).
- R3: Each edge that samples the enable low sets `pin_b` to idle bit 2 (write-data bit 2), with no dead-time.
- R4: For `dt_len` cycles after an active-to-disabled transition, `pin_a` and `pin_an` are both 0.
- R5: With `dt_len` = 0, the pair takes its idle levels on the edge that first samples the enable low.
- R6: Each edge that samples the enable high loads `act_a`, `act_an` and `act_b` into the three pins. This also ends a dead-time early.
- R7: A write (`cfg_we`=1) changes the idle bits only while the captured lock level is 0. A lock request is captured on the edge that sees it. A write on that same edge is still accepted.
- R8: A captured non-zero lock level stays in force when `lock_req` returns to 0. Writes stay ignored until reset.
- R9: Reset drives all pins to 0, clears the idle bits and the lock, and puts the pair in its idle state (no dead-time). After reset, writes are accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_en | input | 1 | Main output enable |
| act_a | input | 1 | Active waveform, channel 1 true |
| act_an | input | 1 | Active waveform, channel 1 complement |
| act_b | input | 1 | Active waveform, channel 2 |
| dt_len | input | DT_W | Dead-time length in clock cycles |
| lock_req | input | 2 | Requested lock level (0 = none, 1..3 = locked) |
| cfg_we | input | 1 | Idle-bit write strobe |
| cfg_wdata | input | 3 | Idle bits: [0] pin_a, [1] pin_an, [2] pin_b |
| pin_a | output | 1 | Channel 1 true output |
| pin_an | output | 1 | Channel 1 complementary output |
| pin_b | output | 1 | Channel 2 output |

## Verification
A dead-time counter that is off by one shows as the pair reaching its idle levels one cycle early or late, on every disable with a non-zero `dt_len`. A wrong sequencer state shows either as a zero-length dead-time (the pair jumps straight to idle) or as an enable that is not followed on the next edge. A lock that leaks would let a later write change the idle pins one cycle after it. A lock that clears itself would show the same way once `lock_req` falls. A cycle-exact reference model in the bench compares all three pins after every edge, so each of these faults shows within one cycle of the stimulus that exposes it.

// File: rtl/oidle_pkg.sv
package oidle_pkg;
    localparam int NIDLE = 3;   // idle bits: [0] pair true, [1] pair complement, [2] second output
    localparam int LOCK_W = 2;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_ACT  = 2'd1,
        M_DEAD = 2'd2
    } pair_mode_e;
endpackage

// File: rtl/oidle_cfg.sv
module oidle_cfg
    import oidle_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [NIDLE-1:0] wdata,
    input  logic [LOCK_W-1:0] lock_req,
    output logic [NIDLE-1:0] idle_bits
);
    typedef struct packed {
        logic [NIDLE-1:0]  idle;
        logic [LOCK_W-1:0] lock;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && (st_q.lock == '0)) st_d.idle = wdata;
        if (st_q.lock == '0)         st_d.lock = lock_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idle_bits = st_q.idle;

    // R7: idle bits frozen while locked
    a_r7_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lock != '0) |=> $stable(st_q.idle));
    // R8: lock level cannot drop without reset
    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lock != '0) |=> (st_q.lock == $past(st_q.lock)));
endmodule

// File: rtl/oidle_seq.sv
module oidle_seq
    import oidle_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            out_en,
    input  logic [DT_W-1:0] dt_len,
    output pair_mode_e      mode_nxt
);
    typedef struct packed {
        pair_mode_e      mode;
        logic [DT_W-1:0] cnt;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (out_en) begin
            st_d.mode = M_ACT;
            st_d.cnt  = '0;
        end else begin
            case (st_q.mode)
                M_ACT: begin
                    if (dt_len == '0) begin
                        st_d.mode = M_IDLE;
                    end else begin
                        st_d.mode = M_DEAD;
                        st_d.cnt  = dt_len - DT_W'(1);
                    end
                end
                M_DEAD: begin
                    if (st_q.cnt == '0) st_d.mode = M_IDLE;
                    else                st_d.cnt  = st_q.cnt - DT_W'(1);
                end
                default: st_d.mode = M_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: M_IDLE, cnt: '0};
        else        st_q <= st_d;
    end

    assign mode_nxt = st_d.mode;

    // R5: zero dead-time goes straight to idle
    a_r5_zero_dt: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en && st_q.mode == M_ACT && dt_len == '0) |=> (st_q.mode == M_IDLE));
    // R1: dead-time ends when its count runs out
    a_r1_dead_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en && st_q.mode == M_DEAD && st_q.cnt == '0) |=> (st_q.mode == M_IDLE));
endmodule

// File: rtl/oidle_ctrl.sv
module oidle_ctrl
    import oidle_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            out_en,
    input  logic            act_a,
    input  logic            act_an,
    input  logic            act_b,
    input  logic [DT_W-1:0] dt_len,
    input  logic [1:0]      lock_req,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_wdata,
    output logic            pin_a,
    output logic            pin_an,
    output logic            pin_b
);
    typedef struct packed {
        logic a;
        logic an;
        logic b;
    } pins_t;

    logic [NIDLE-1:0] idle_bits;
    pair_mode_e       mode_nxt;
    pins_t            pins_d, pins_q;

    oidle_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .wdata     (cfg_wdata),
        .lock_req  (lock_req),
        .idle_bits (idle_bits)
    );

    oidle_seq #(.DT_W(DT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .out_en   (out_en),
        .dt_len   (dt_len),
        .mode_nxt (mode_nxt)
    );

    always_comb begin
        if (out_en) begin
            pins_d = '{a: act_a, an: act_an, b: act_b};
        end else begin
            pins_d.b = idle_bits[2];
            if (mode_nxt == M_IDLE) begin
                pins_d.a  = idle_bits[0];
                pins_d.an = idle_bits[1];
            end else begin
                pins_d.a  = 1'b0;
                pins_d.an = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pins_q <= '0;
        else        pins_q <= pins_d;
    end

    assign pin_a  = pins_q.a;
    assign pin_an = pins_q.an;
    assign pin_b  = pins_q.b;

    // R6: active values pass one edge later
    a_r6_pass: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |=> (pin_a == $past(act_a) && pin_an == $past(act_an) && pin_b == $past(act_b)));
    // R3: second output idles with no dead-time
    a_r3_b_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> (pin_b == $past(idle_bits[2])));
    // R4: pair off during dead-time
    a_r4_pair_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en && mode_nxt == M_DEAD) |=> (!pin_a && !pin_an));
    // R2: pair complement at idle level once idle
    a_r2_pair_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en && mode_nxt == M_IDLE) |=> (pin_an == $past(idle_bits[1]) && pin_a == $past(idle_bits[0])));
endmodule

// File: tb/sim_oidle_ctrl.sv
`timescale 1ns/1ps
module sim_oidle_ctrl;
    localparam int DT_W = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            out_en = 1'b0, act_a = 1'b0, act_an = 1'b0, act_b = 1'b0;
    logic [DT_W-1:0] dt_len = '0;
    logic [1:0]      lock_req = '0;
    logic            cfg_we = 1'b0;
    logic [2:0]      cfg_wdata = '0;
    logic            pin_a, pin_an, pin_b;

    oidle_ctrl #(.DT_W(DT_W)) u0 (.*);

    int n_chk = 0, n_fail = 0;
    // reference model: 0 idle, 1 active, 2 dead
    int         m_mode = 0, m_cnt = 0;
    logic [2:0] m_idle = '0;
    logic [1:0] m_lock = '0;
    logic [2:0] m_pins = '0;   // {b, an, a}
    string      ctx = "";
    string      tag_pair, tag_b;

    task automatic chk(string tag, string nm, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, nm, act, exp);
        end
    endtask

    task automatic model_step();
        int nm;
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_idle = '0; m_lock = '0; m_pins = '0;
            tag_pair = "R9"; tag_b = "R9";
            return;
        end
        nm = m_mode;
        tag_pair = "R1"; tag_b = "R3";
        if (out_en) begin
            nm = 1; tag_pair = "R6"; tag_b = "R6";
        end else begin
            case (m_mode)
                1: if (dt_len == 0) begin nm = 0; tag_pair = "R5"; end
                   else begin nm = 2; m_cnt = int'(dt_len) - 1; tag_pair = "R4"; end
                2: if (m_cnt == 0) nm = 0;
                   else begin m_cnt--; tag_pair = "R4"; end
                default: nm = 0;
            endcase
        end
        if (out_en) m_pins = {act_b, act_an, act_a};
        else begin
            m_pins[2] = m_idle[2];
            m_pins[1:0] = (nm == 0) ? m_idle[1:0] : 2'b00;
        end
        m_mode = nm;
        if (cfg_we && m_lock == 0) m_idle = cfg_wdata;
        if (m_lock == 0) m_lock = lock_req;
    endtask

    task automatic cycle();
        string tp, tb2;
        @(posedge clk);
        model_step();
        @(negedge clk);
        tp  = (ctx != "") ? ctx : tag_pair;
        tb2 = (ctx != "") ? ctx : tag_b;
        chk(tp, "pin_a", pin_a, m_pins[0]);
        chk((ctx != "") ? ctx : ((tag_pair == "R1") ? "R2" : tp), "pin_an", pin_an, m_pins[1]);
        chk(tb2, "pin_b", pin_b, m_pins[2]);
    endtask

    task automatic write_idle(logic [2:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        cycle();
        cfg_we = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R9: reset state
        @(negedge clk);
        ctx = "R9";
        repeat (3) cycle();
        rst_n = 1'b1;
        cycle();
        write_idle(3'b101);
        repeat (2) cycle();
        ctx = "";
        // R6 then R5: zero dead-time
        out_en = 1'b1; act_a = 1; act_an = 0; act_b = 1;
        cycle();
        act_a = 0; act_an = 1; act_b = 0;
        cycle();
        dt_len = 0; out_en = 1'b0;
        repeat (3) cycle();
        // R4/R1/R2: dead-time of 3
        write_idle(3'b011);
        out_en = 1'b1; act_a = 1; act_an = 1; act_b = 1;
        repeat (2) cycle();
        dt_len = 3; out_en = 1'b0;
        repeat (6) cycle();
        // R6: enable returns mid dead-time
        out_en = 1'b1; cycle();
        dt_len = 5; out_en = 1'b0; repeat (2) cycle();
        out_en = 1'b1; act_a = 0; act_an = 1; act_b = 0; cycle();
        out_en = 1'b0; repeat (7) cycle();
        // constrained random, unlocked
        for (int i = 0; i < 1500; i++) begin
            if ($urandom_range(7) == 0) out_en = ~out_en;
            act_a  = 1'($urandom); act_an = 1'($urandom); act_b = 1'($urandom);
            dt_len = DT_W'($urandom_range(4));
            cfg_we = ($urandom_range(3) == 0);
            cfg_wdata = 3'($urandom);
            cycle();
        end
        cfg_we = 1'b0; out_en = 1'b0; dt_len = 0;
        repeat (2) cycle();
        // R7: lock then try writes while idle
        write_idle(3'b010);
        lock_req = 2'd2; cycle();
        lock_req = 2'd2;
        ctx = "R7";
        for (int i = 0; i < 8; i++) write_idle(3'($urandom) | 3'b101);
        // R8: lock request released, still locked
        ctx = "R8";
        lock_req = 2'd0;
        for (int i = 0; i < 8; i++) write_idle(~3'b010);
        lock_req = 2'd1; write_idle(3'b111);
        lock_req = 2'd0; repeat (2) cycle();
        // R9: reset clears lock, writes accepted again
        ctx = "R9";
        rst_n = 1'b0; repeat (2) cycle();
        rst_n = 1'b1; cycle();
        write_idle(3'b110);
        repeat (2) cycle();
        ctx = "";
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule